// File: doc/BRIEF.md
# Segmented physical address generator

This block turns segment:offset pairs into 20-bit physical addresses for a 16-bit processor core. It holds four 16-bit segment bases: code, data, stack and extra. Each of them can be loaded through a write port. Each access is presented as a kind plus an offset. The block picks the segment that the kind calls for and adds the offset to that segment shifted left by four bits. The sum wraps within the 20-bit space. The block also reports a 2-bit code that names the segment it used.

The block owns the stack pointer. A push produces the address of SP minus two and moves SP there at the clock edge. A pop produces the address of the current SP and then raises SP by two. Ordinary data accesses use the data segment by default. An override input may redirect a data access to any of the four segments. Instruction fetches, stack accesses and string-destination accesses ignore the override. Address and code are combinational from the inputs and the registered state. Loads of segments and of SP take effect at the rising edge.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset all four segment bases and SP are zero, so a fetch at offset 0 yields address 00000.
- R2: The address is (segment << 4) + zero-extended offset, taken modulo 2^20. For example A4FB:4872 gives A9822, 028F:0030 gives 02920, and FFFF:0010 wraps to 00000.
- R3: Access kind 0 (fetch) uses the code segment with the offset input and drives code 2'b10, whatever the override inputs are.
- R4: Access kind 1 (data), and the unused kinds 5 to 7, use the data segment (code 2'b11) when `ovr_en` is low. When `ovr_en` is high they use the segment named by `ovr_seg` and drive that value as the code.
- R5: Access kind 4 (string destination) uses the extra segment with the offset input and drives code 2'b00, whatever the override inputs are.
- R6: Access kind 2 (push) addresses stack:(SP-2) with code 2'b01. When `acc_valid` is high, SP becomes SP-2 at the edge. SP wraps modulo 2^16.
- R7: Access kind 3 (pop) addresses stack:SP with code 2'b01. When `acc_valid` is high, SP becomes SP+2 at the edge.
- R8: With `seg_we` high, the segment named by `seg_idx` takes `seg_wdata` at the edge. The index uses the same codes: 00 extra, 01 stack, 10 code, 11 data. An access in the same cycle still sees the old base.
- R9: With `sp_we` high, SP takes `sp_wdata` at the edge, and this load wins over any push or pop adjustment in the same cycle.
- R10: SP does not change when `acc_valid` is low or the kind is neither push nor pop, unless `sp_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| seg_we | input | 1 | Segment load strobe |
| seg_idx | input | 2 | Segment to load (00 extra, 01 stack, 10 code, 11 data) |
| seg_wdata | input | 16 | New segment base |
| sp_we | input | 1 | SP load strobe |
| sp_wdata | input | 16 | New SP value |
| acc_valid | input | 1 | Access is real; push/pop adjust SP only when high |
| acc_kind | input | 3 | 0 fetch, 1 data, 2 push, 3 pop, 4 string destination |
| acc_off | input | 16 | Offset for fetch, data and string-destination accesses |
| ovr_en | input | 1 | Override the segment of a data access |
| ovr_seg | input | 2 | Override segment code |
| phys_addr | output | 20 | Physical address |
| seg_code | output | 2 | Code of the segment used |
| sp_out | output | 16 | Current stack pointer |

## Verification
The assertions assume that reset is applied before the first access and that `acc_kind` is always driven to a known value. They also assume that any cycle with `sp_we` high is meant to replace the push or pop step, not to combine with it. The stimulus drives every input on the falling edge from a fixed-seed random stream. It draws kinds only from the defined range and overrides only on data accesses, and it mixes in SP loads that collide with push and pop. Directed cases add the worked address examples, the 20-bit wrap, SP wrap below zero, and a segment load in the same cycle as a fetch.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int DW    = 16,
  parameter int SHIFT = 4,
  parameter int STEP  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  seg_we,
  input  logic [1:0]            seg_idx,
  input  logic [DW-1:0]         seg_wdata,
  input  logic                  sp_we,
  input  logic [DW-1:0]         sp_wdata,
  input  logic                  acc_valid,
  input  logic [2:0]            acc_kind,
  input  logic [DW-1:0]         acc_off,
  input  logic                  ovr_en,
  input  logic [1:0]            ovr_seg,
  output logic [DW+SHIFT-1:0]   phys_addr,
  output logic [1:0]            seg_code,
  output logic [DW-1:0]         sp_out
);
  localparam int AW = DW + SHIFT;
  localparam logic [DW-1:0] STEP_V = DW'(STEP);
  localparam logic [2:0] K_FETCH = 3'd0, K_PUSH = 3'd2, K_POP = 3'd3, K_STR = 3'd4;

  logic [DW-1:0] seg_q [4];
  logic [DW-1:0] sp_q;
  logic [DW-1:0] off;
  logic [1:0]    code;

  always_comb begin
    off = acc_off;
    case (acc_kind)
      K_FETCH: code = 2'b10;
      K_PUSH:  begin code = 2'b01; off = sp_q - STEP_V; end
      K_POP:   begin code = 2'b01; off = sp_q; end
      K_STR:   code = 2'b00;
      default: code = ovr_en ? ovr_seg : 2'b11;
    endcase
  end

  assign seg_code  = code;
  assign sp_out    = sp_q;
  assign phys_addr = {seg_q[code], {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) seg_q[i] <= '0;
    end else if (seg_we) begin
      seg_q[seg_idx] <= seg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               sp_q <= '0;
    else if (sp_we)                           sp_q <= sp_wdata;
    else if (acc_valid && acc_kind == K_PUSH) sp_q <= sp_q - STEP_V;
    else if (acc_valid && acc_kind == K_POP)  sp_q <= sp_q + STEP_V;
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sp_we,
  input logic [DW-1:0] sp_wdata,
  input logic          acc_valid,
  input logic [2:0]    acc_kind,
  input logic [1:0]    seg_code,
  input logic [DW-1:0] sp_out
);
  localparam logic [DW-1:0] TWO = DW'(2);

  assert_fetch_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_kind == 3'd0 |-> seg_code == 2'b10);

  assert_str_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_kind == 3'd4 |-> seg_code == 2'b00);

  assert_push_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == 3'd2 && !sp_we |=> sp_out == $past(sp_out) - TWO);

  assert_pop_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == 3'd3 && !sp_we |=> sp_out == $past(sp_out) + TWO);

  assert_sp_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |=> sp_out == $past(sp_wdata));

  assert_sp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_we && !(acc_valid && (acc_kind == 3'd2 || acc_kind == 3'd3)) |=> $stable(sp_out));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sp_we(sp_we), .sp_wdata(sp_wdata),
  .acc_valid(acc_valid), .acc_kind(acc_kind), .seg_code(seg_code), .sp_out(sp_out)
);

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
  logic clk = 0, rst_n = 0;
  logic seg_we = 0, sp_we = 0, acc_valid = 0, ovr_en = 0;
  logic [1:0] seg_idx = 0, ovr_seg = 0;
  logic [15:0] seg_wdata = 0, sp_wdata = 0, acc_off = 0;
  logic [2:0] acc_kind = 0;
  logic [19:0] phys_addr;
  logic [1:0] seg_code;
  logic [15:0] sp_out;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_seg [4];
  logic [15:0] m_sp;

  always #2 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_idx(seg_idx), .seg_wdata(seg_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_off(acc_off), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .phys_addr(phys_addr), .seg_code(seg_code), .sp_out(sp_out)
  );

  function automatic logic [19:0] lin(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] t;
    t = {1'b0, s, 4'h0} + {5'h0, o};
    return t[19:0];
  endfunction

  function automatic logic [1:0] exp_code(input logic [2:0] k, input logic oe, input logic [1:0] os);
    case (k)
      3'd0: return 2'b10;
      3'd2, 3'd3: return 2'b01;
      3'd4: return 2'b00;
      default: return oe ? os : 2'b11;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic sw, input logic [1:0] si, input logic [15:0] sd,
                      input logic pw, input logic [15:0] pd,
                      input logic v, input logic [2:0] k, input logic [15:0] o,
                      input logic oe, input logic [1:0] os, input string tag);
    logic [1:0] c;
    logic [15:0] eo;
    @(negedge clk);
    seg_we = sw; seg_idx = si; seg_wdata = sd; sp_we = pw; sp_wdata = pd;
    acc_valid = v; acc_kind = k; acc_off = o; ovr_en = oe; ovr_seg = os;
    #1;
    c = exp_code(k, oe, os);
    eo = (k == 3'd2) ? m_sp - 16'd2 : (k == 3'd3) ? m_sp : o;
    chk({tag, " code"}, 32'(seg_code), 32'(c));
    chk({tag, " addr"}, 32'(phys_addr), 32'(lin(m_seg[c], eo)));
    @(posedge clk);
    if (sw) m_seg[si] = sd;
    if (pw) m_sp = pd;
    else if (v && k == 3'd2) m_sp = m_sp - 16'd2;
    else if (v && k == 3'd3) m_sp = m_sp + 16'd2;
    #1;
    chk({tag, " sp"}, 32'(sp_out), 32'(m_sp));
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) m_seg[i] = 16'h0;
    m_sp = 16'h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sp reset", 32'(sp_out), 32'h0);
    rst_n = 1;
    step(0,0,0, 0,0, 1,3'd0,16'h0000, 0,0, "R1");
    // segment load: same-cycle fetch sees old CS
    step(1,2'b10,16'hA4FB, 0,0, 1,3'd0,16'h4872, 0,0, "R8");
    step(0,0,0, 0,0, 1,3'd0,16'h4872, 1,2'b11, "R3");
    chk("R2 worked A4FB:4872", 32'(lin(16'hA4FB,16'h4872)), 32'h000A9822);
    step(1,2'b11,16'h028F, 0,0, 0,3'd1,16'h0, 0,0, "R8");
    step(0,0,0, 0,0, 1,3'd1,16'h0030, 0,0, "R2");
    step(1,2'b11,16'hFFFF, 0,0, 0,3'd0,16'h0, 0,0, "R8");
    step(0,0,0, 0,0, 1,3'd1,16'h0010, 0,0, "R2 wrap");
    step(1,2'b00,16'h1234, 0,0, 0,3'd0,16'h0, 0,0, "R8");
    step(0,0,0, 0,0, 1,3'd1,16'h0100, 1,2'b00, "R4 override");
    step(0,0,0, 0,0, 1,3'd1,16'h0100, 1,2'b10, "R4 override");
    step(0,0,0, 0,0, 1,3'd4,16'h0200, 1,2'b11, "R5");
    // stack
    step(1,2'b01,16'h0A00, 0,0, 1,3'd2,16'h0, 0,0, "R6 wrap below zero");
    step(0,0,0, 1,16'h0100, 0,3'd0,16'h0, 0,0, "R9");
    step(0,0,0, 0,0, 1,3'd2,16'h5555, 0,0, "R6");
    step(0,0,0, 0,0, 1,3'd3,16'h5555, 0,0, "R7");
    step(0,0,0, 1,16'h0800, 1,3'd2,16'h0, 0,0, "R9 load beats push");
    step(0,0,0, 1,16'h0900, 1,3'd3,16'h0, 0,0, "R9 load beats pop");
    step(0,0,0, 0,0, 0,3'd2,16'h0, 0,0, "R10 idle push");
    step(0,0,0, 0,0, 1,3'd1,16'h0, 0,0, "R10 data");
    for (int n = 0; n < 400; n++) begin
      logic sw, pw, oe;
      logic [2:0] k;
      sw = ($urandom_range(0, 3) == 0);
      pw = ($urandom_range(0, 7) == 0);
      k = 3'($urandom_range(0, 4));
      oe = (k == 3'd1) && $urandom_range(0, 1) == 1;
      step(sw, 2'($urandom), 16'($urandom), pw, 16'($urandom),
           1'($urandom), k, 16'($urandom), oe, 2'($urandom), "R2-random R4 R6 R7");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule